// File: doc/BRIEF.md
# Restartable Indexed Gather/Scatter Address Sequencer

This block walks the elements of one indexed vector load or store, in order, and turns each into a physical memory request. For every element it reads the index from a register-file read port, scales it by the element size, adds the base address, and translates the virtual page through a small fully associative translation buffer. A hit with suitable permission issues one memory request. A lookup that misses, or a store to a page that is not writable, stops the walk at that element. No request is made for that element. The block then raises a one-cycle exception pulse with the virtual page number, and keeps the element's number in a first-fault register.

Every element that precedes the faulting one has already gone out to memory, so the instruction has partly committed. The trap handler installs the missing mapping through the fill port and reissues the command with the resume flag set. The walk then continues from the recorded element rather than from element zero. After each handled fault at least the faulting element completes, so the walk always moves forward, even with one buffer entry. The number of entries therefore changes only speed and not results.

The memory request side is a valid/ready stream. While `mem_valid` is high and `mem_ready` is low, the request holds with an unchanged payload and the sequencer does not advance. Command acceptance is a valid/ready handshake. Completion, exception and fill are plain single-cycle strobes.

Top module: `gather_scatter_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `mem_valid`, `done` and `exc_valid` are 0, and `ff_elem` is 0.
- R2: Element e has virtual address `cmd_base + (index_e << ESZ_LOG2)`. Its request carries physical address {ppn, virtual address bits [PG-1:0]}. A store request carries `rf_wdata` read for that element, with `mem_write` set to 1.
- R3: Elements are issued in ascending order, one per cycle while `mem_ready` is high, and `mem_elem` gives the element number.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, the request stays asserted with the same element and address on the next cycle.
- R5: On a translation miss, no request is made for that element. One cycle later `exc_valid` pulses for exactly one cycle with `exc_cause` = 0 and `exc_vpn` = the faulting virtual page. `ff_elem` then holds the element number, and `cmd_ready` returns to 1.
- R6: A store to a page installed with write permission 0 faults in the same way, but with `exc_cause` = 1. A load from such a page hits normally.
- R7: Every element before the faulting one is issued to memory before the exception is reported.
- R8: A command with `cmd_resume` = 1 starts at `ff_elem`. A command with `cmd_resume` = 0 starts at element 0.
- R9: `done` pulses for one cycle after the last element's handshake, or one cycle after acceptance when no elements remain. When `done` pulses, `ff_elem` is cleared to 0. `done` and `exc_valid` never pulse together.
- R10: A `fill_valid` strobe installs a mapping. A page already present is updated in place. Otherwise the next slot in rotating order is replaced, evicting its old page.
- R11: While a command is running, `cmd_ready` is 0 and a new `cmd_valid` has no effect on the requests issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_resume | input | 1 | Start at the recorded first-fault element |
| cmd_base | input | AW | Base virtual address |
| cmd_len | input | EW | Vector length in elements |
| rf_elem | output | EW | Element number being read from the register file |
| rf_index | input | IW | Index value for `rf_elem` |
| rf_wdata | input | DW | Store data for `rf_elem` |
| fill_valid | input | 1 | Install translation strobe |
| fill_vpn | input | VPNW | Virtual page to install |
| fill_ppn | input | VPNW | Physical page to install |
| fill_wok | input | 1 | Page is writable |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Request is a write |
| mem_paddr | output | AW | Physical address |
| mem_wdata | output | DW | Write data |
| mem_elem | output | EW | Element number of the request |
| done | output | 1 | Instruction completed strobe |
| exc_valid | output | 1 | Exception strobe |
| exc_cause | output | 1 | 0 = miss, 1 = write not permitted |
| exc_vpn | output | VPNW | Faulting virtual page |
| ff_elem | output | EW | First-fault element register |

## Verification
A wrong element counter would show up on `mem_elem`, and in the address of the very next request, in the first cycle it went wrong. A wrong restart point would show in the first request after a resumed command. A stale or duplicated translation entry would show as a wrong physical page on the next request to that page, or as a fault where a hit was expected. A wrong first-fault capture would show on `ff_elem` the cycle after the exception pulse and would hold until the next command. The bench therefore checks every request's element number and address, and also checks the register after each command ends.

// File: rtl/idxseq_pkg.sv
package idxseq_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_t;

  typedef enum logic {
    CAUSE_MISS = 1'b0,
    CAUSE_PERM = 1'b1
  } exc_cause_t;
endpackage

// File: rtl/idxseq_agen.sv
module idxseq_agen #(
  parameter int AW       = 32,
  parameter int IW       = 32,
  parameter int ESZ_LOG2 = 2,
  parameter int PG       = 12,
  localparam int VPNW    = AW - PG
) (
  input  logic [AW-1:0]   base,
  input  logic [IW-1:0]   index,
  output logic [VPNW-1:0] vpn,
  output logic [PG-1:0]   offset
);
  logic [AW-1:0] scaled;
  logic [AW-1:0] vaddr;

  // element byte offset: index scaled by element size
  assign scaled = AW'(index) << ESZ_LOG2;
  assign vaddr  = base + scaled;
  assign vpn    = vaddr[AW-1:PG];
  assign offset = vaddr[PG-1:0];
endmodule

// File: rtl/idxseq_tlb.sv
module idxseq_tlb #(
  parameter int VPNW    = 20,
  parameter int ENTRIES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VPNW-1:0] lk_vpn,
  output logic            lk_hit,
  output logic [VPNW-1:0] lk_ppn,
  output logic            lk_wok,
  input  logic            fill_valid,
  input  logic [VPNW-1:0] fill_vpn,
  input  logic [VPNW-1:0] fill_ppn,
  input  logic            fill_wok
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_vld;
  logic [ENTRIES-1:0] e_wok;
  logic [VPNW-1:0]    e_vpn [ENTRIES];
  logic [VPNW-1:0]    e_ppn [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic [PW-1:0]      victim;
  logic [PW-1:0]      fl_slot;
  logic               fl_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = e_vld[g] && (e_vpn[g] == lk_vpn);
    assign fl_match[g] = e_vld[g] && (e_vpn[g] == fill_vpn);
  end

  always_comb begin
    lk_hit = |lk_match;
    lk_ppn = '0;
    lk_wok = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn = e_ppn[i];
        lk_wok = e_wok[i];
      end
    end
  end

  // a page already held is refreshed in place, otherwise rotate
  always_comb begin
    fl_hit  = |fl_match;
    fl_slot = victim;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fl_match[i]) fl_slot = PW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_wok  <= '0;
      victim <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0;
        e_ppn[i] <= '0;
      end
    end else if (fill_valid) begin
      e_vld[fl_slot] <= 1'b1;
      e_wok[fl_slot] <= fill_wok;
      e_vpn[fl_slot] <= fill_vpn;
      e_ppn[fl_slot] <= fill_ppn;
      if (!fl_hit) begin
        victim <= (victim == PW'(ENTRIES - 1)) ? '0 : victim + PW'(1);
      end
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R10
endmodule

// File: rtl/idxseq_ctrl.sv
module idxseq_ctrl
  import idxseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int EW   = 5,
  parameter int VPNW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_store,
  input  logic            cmd_resume,
  input  logic [AW-1:0]   cmd_base,
  input  logic [EW-1:0]   cmd_len,
  output logic [EW-1:0]   elem,
  output logic [AW-1:0]   base_q,
  output logic            store_q,
  input  logic            hit,
  input  logic            wok,
  input  logic [VPNW-1:0] vpn,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            done,
  output logic            exc_valid,
  output logic            exc_cause,
  output logic [VPNW-1:0] exc_vpn,
  output logic [EW-1:0]   ff_elem
);
  sq_state_t  state;
  logic [EW-1:0] len_q;
  logic       running;
  logic       at_end;
  logic       legal;
  exc_cause_t cause_now;

  assign running   = (state == SQ_RUN);
  assign at_end    = (elem >= len_q);
  assign legal     = hit && (!store_q || wok);
  assign cause_now = hit ? CAUSE_PERM : CAUSE_MISS;
  assign mem_valid = running && !at_end && legal;
  assign cmd_ready = (state == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      elem      <= '0;
      len_q     <= '0;
      base_q    <= '0;
      store_q   <= 1'b0;
      ff_elem   <= '0;
      done      <= 1'b0;
      exc_valid <= 1'b0;
      exc_cause <= 1'b0;
      exc_vpn   <= '0;
    end else begin
      done      <= 1'b0;
      exc_valid <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (cmd_valid) begin
            elem    <= cmd_resume ? ff_elem : '0;
            len_q   <= cmd_len;
            base_q  <= cmd_base;
            store_q <= cmd_store;
            state   <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (at_end) begin
            done    <= 1'b1;
            ff_elem <= '0;
            state   <= SQ_IDLE;
          end else if (!legal) begin
            exc_valid <= 1'b1;
            exc_cause <= cause_now;
            exc_vpn   <= vpn;
            ff_elem   <= elem;
            state     <= SQ_IDLE;
          end else if (mem_ready) begin
            elem <= elem + EW'(1);
            if ((elem + EW'(1)) == len_q) begin
              done    <= 1'b1;
              ff_elem <= '0;
              state   <= SQ_IDLE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(elem))); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (elem == $past(elem) + EW'(1))); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ff_elem == '0)); // R9
  AST_EXC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (cmd_ready && !mem_valid)); // R5
  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid); // R5
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && done)); // R9
endmodule

// File: rtl/gather_scatter_seq.sv
module gather_scatter_seq #(
  parameter int AW       = 32,
  parameter int IW       = 32,
  parameter int DW       = 32,
  parameter int PG       = 12,
  parameter int ESZ_LOG2 = 2,
  parameter int ENTRIES  = 2,
  parameter int VLMAX    = 16,
  localparam int VPNW    = AW - PG,
  localparam int EW      = $clog2(VLMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_store,
  input  logic            cmd_resume,
  input  logic [AW-1:0]   cmd_base,
  input  logic [EW-1:0]   cmd_len,
  output logic [EW-1:0]   rf_elem,
  input  logic [IW-1:0]   rf_index,
  input  logic [DW-1:0]   rf_wdata,
  input  logic            fill_valid,
  input  logic [VPNW-1:0] fill_vpn,
  input  logic [VPNW-1:0] fill_ppn,
  input  logic            fill_wok,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [AW-1:0]   mem_paddr,
  output logic [DW-1:0]   mem_wdata,
  output logic [EW-1:0]   mem_elem,
  output logic            done,
  output logic            exc_valid,
  output logic            exc_cause,
  output logic [VPNW-1:0] exc_vpn,
  output logic [EW-1:0]   ff_elem
);
  logic [EW-1:0]   elem;
  logic [AW-1:0]   base_q;
  logic            store_q;
  logic [VPNW-1:0] va_page;
  logic [PG-1:0]   va_off;
  logic            tl_hit;
  logic            tl_wok;
  logic [VPNW-1:0] tl_ppn;

  idxseq_agen #(.AW(AW), .IW(IW), .ESZ_LOG2(ESZ_LOG2), .PG(PG)) u_agen (
    .base(base_q), .index(rf_index), .vpn(va_page), .offset(va_off)
  );

  idxseq_tlb #(.VPNW(VPNW), .ENTRIES(ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(va_page), .lk_hit(tl_hit), .lk_ppn(tl_ppn), .lk_wok(tl_wok),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_wok(fill_wok)
  );

  idxseq_ctrl #(.AW(AW), .EW(EW), .VPNW(VPNW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
    .cmd_resume(cmd_resume), .cmd_base(cmd_base), .cmd_len(cmd_len),
    .elem(elem), .base_q(base_q), .store_q(store_q),
    .hit(tl_hit), .wok(tl_wok), .vpn(va_page),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_vpn(exc_vpn), .ff_elem(ff_elem)
  );

  assign rf_elem   = elem;
  assign mem_elem  = elem;
  assign mem_write = store_q;
  assign mem_wdata = rf_wdata;
  assign mem_paddr = {tl_ppn, va_off};

  AST_WRITE_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (tl_hit && tl_wok)); // R6
  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_paddr)); // R4
endmodule

// File: tb/gather_scatter_seq_test.sv
module gather_scatter_seq_test;
  localparam int AW = 32;
  localparam int EW = 5;
  localparam int VPNW = 20;

  typedef struct packed {
    logic        store;
    logic        resume;
    logic [31:0] base;
    logic [4:0]  len;
    logic [7:0]  stall;
    logic [4:0]  exp_start;
    logic [4:0]  exp_cnt;
    logic        exp_exc;
    logic        exp_cause;
    logic [19:0] exp_vpn;
    logic [4:0]  exp_ff;
  } row_t;

  // store, resume, base, len, stall, start, count, exc, cause, vpn, ff
  localparam row_t ROWS [5] = '{
    '{1'b0, 1'b0, 32'h0001_0F80, 5'd16, 8'h00, 5'd0, 5'd16, 1'b0, 1'b0, 20'h0, 5'd0},
    '{1'b0, 1'b0, 32'h0001_0F80, 5'd5,  8'h05, 5'd0, 5'd5,  1'b0, 1'b0, 20'h0, 5'd0},
    '{1'b0, 1'b0, 32'h0001_0F80, 5'd0,  8'h00, 5'd0, 5'd0,  1'b0, 1'b0, 20'h0, 5'd0},
    '{1'b1, 1'b0, 32'h0001_0F80, 5'd16, 8'h00, 5'd0, 5'd11, 1'b1, 1'b1, 20'h11, 5'd11},
    '{1'b0, 1'b0, 32'h0001_1F80, 5'd16, 8'h00, 5'd0, 5'd11, 1'b1, 1'b0, 20'h12, 5'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_store = 1'b0, cmd_resume = 1'b0;
  logic [AW-1:0] cmd_base = '0;
  logic [EW-1:0] cmd_len = '0;
  logic cmd_ready;
  logic [EW-1:0] rf_elem;
  logic [31:0] rf_index, rf_wdata;
  logic fill_valid = 1'b0, fill_wok = 1'b0;
  logic [VPNW-1:0] fill_vpn = '0, fill_ppn = '0;
  logic mem_valid, mem_write, mem_ready = 1'b0;
  logic [AW-1:0] mem_paddr;
  logic [31:0] mem_wdata;
  logic [EW-1:0] mem_elem, ff_elem;
  logic done, exc_valid, exc_cause;
  logic [VPNW-1:0] exc_vpn;

  int checks = 0;
  int fails = 0;
  logic wok11 = 1'b0;
  logic map10 = 1'b1;

  always #10 clk = ~clk;

  assign rf_index = 32'(rf_elem) * 32'd3;
  assign rf_wdata = 32'hD000 + 32'(rf_elem);

  gather_scatter_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_resume(cmd_resume), .cmd_base(cmd_base),
    .cmd_len(cmd_len), .rf_elem(rf_elem), .rf_index(rf_index),
    .rf_wdata(rf_wdata), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_wok(fill_wok), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_paddr(mem_paddr),
    .mem_wdata(mem_wdata), .mem_elem(mem_elem), .done(done),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_vpn(exc_vpn),
    .ff_elem(ff_elem)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] ppn_of(input logic [19:0] vpn);
    return 20'h3A + (vpn - 20'h10);
  endfunction

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic wok);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wok = wok;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic run_row(input row_t r);
    int cnt = 0;
    int nxt;
    logic [31:0] va, pa;
    logic seen_exc = 1'b0, seen_cause = 1'b0;
    logic [19:0] seen_vpn = '0;
    nxt = int'(r.exp_start);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_store = r.store; cmd_resume = r.resume;
    cmd_base = r.base; cmd_len = r.len;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      mem_ready = (cyc < 8) ? !r.stall[cyc] : 1'b1;
      #1;
      if (done || exc_valid) begin
        seen_exc = exc_valid; seen_cause = exc_cause; seen_vpn = exc_vpn;
        break;
      end
      chk(cmd_ready == 1'b0, "R11 busy ready", 32'(cmd_ready), 0);
      if (mem_valid && mem_ready) begin
        va = r.base + 32'(nxt) * 32'd12;
        pa = {ppn_of(va[31:12]), va[11:0]};
        chk(int'(mem_elem) == nxt, "R3 element order", 32'(mem_elem), 32'(nxt));
        chk(mem_paddr == pa, "R2 physical address", mem_paddr, pa);
        chk(mem_write == r.store, "R2 write flag", 32'(mem_write), 32'(r.store));
        if (r.store) chk(mem_wdata == 32'hD000 + 32'(nxt), "R2 store data", mem_wdata, 32'hD000 + 32'(nxt));
        nxt++; cnt++;
      end
      if (cyc == 1) begin
        cmd_valid = 1'b1; cmd_base = 32'h7777_0000; cmd_len = 5'd1; // R11
      end
    end
    cmd_valid = 1'b0;
    mem_ready = 1'b0;
    chk(cnt == int'(r.exp_cnt), "R7 issued count", 32'(cnt), 32'(r.exp_cnt));
    chk(seen_exc == r.exp_exc, "R5 exception raised", 32'(seen_exc), 32'(r.exp_exc));
    if (r.exp_exc) begin
      chk(seen_cause == r.exp_cause, "R6 exception cause", 32'(seen_cause), 32'(r.exp_cause));
      chk(seen_vpn == r.exp_vpn, "R5 exception vpn", 32'(seen_vpn), 32'(r.exp_vpn));
    end
    chk(ff_elem == r.exp_ff, "R9 first-fault register", 32'(ff_elem), 32'(r.exp_ff));
    @(negedge clk);
    chk(!exc_valid && !done, "R5 single-cycle strobe", 32'(exc_valid), 0);
    chk(cmd_ready == 1'b1, "R5 ready after end", 32'(cmd_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    row_t d;
    repeat (3) @(negedge clk);
    #1;
    chk(cmd_ready == 1'b1, "R1 reset ready", 32'(cmd_ready), 1);
    chk(!mem_valid && !done && !exc_valid, "R1 reset strobes", 32'({mem_valid, done, exc_valid}), 0);
    chk(ff_elem == '0, "R1 reset ff", 32'(ff_elem), 0);
    rst_n = 1'b1;
    fill(20'h10, ppn_of(20'h10), 1'b1);
    fill(20'h11, ppn_of(20'h11), 1'b0);
    // table walk: R3 R4 R6 R8 (resume=0 after fault starts at 0) R9
    for (int i = 0; i < 5; i++) run_row(ROWS[i]);
    // R10 fill page 0x12: evicts page 0x10 in rotating order
    fill(20'h12, ppn_of(20'h12), 1'b1);
    // R8 resume from the recorded element 11
    d = '{1'b0, 1'b1, 32'h0001_1F80, 5'd16, 8'h12, 5'd11, 5'd5, 1'b0, 1'b0, 20'h0, 5'd0};
    run_row(d);
    // R10 page 0x10 was evicted: miss at element 0, nothing issued
    d = '{1'b0, 1'b0, 32'h0001_0F80, 5'd2, 8'h00, 5'd0, 5'd0, 1'b1, 1'b0, 20'h10, 5'd0};
    run_row(d);
    // R10 refresh page 0x11 in place as writable; page 0x12 stays: R6 store passes
    fill(20'h11, ppn_of(20'h11), 1'b1);
    d = '{1'b1, 1'b0, 32'h0001_1F80, 5'd16, 8'h00, 5'd0, 5'd16, 1'b0, 1'b0, 20'h0, 5'd0};
    run_row(d);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule